// File: doc/BRIEF.md
# Coprocessor Type Detection Latch

This block decides, once after every reset, which kind of numeric coprocessor sits on the board, and remembers the answer in a type bit of control register zero. The coprocessor's active-low error line idles in opposite states on the two supported coprocessor types. It idles high on the narrow (16-bit protocol) type and low on the wide (32-bit protocol) type. The block passes that line through a synchroniser and takes one sample of it. A low level sets the type bit. A high level clears it. A missing coprocessor also leaves the line high, so it also reads as the narrow type.

The sample is taken a fixed number of clocks after reset is released. If the core signals that the first escape instruction is about to issue before that count runs out, the sample is taken on that edge instead. The type bit drives the protocol-width select that the coprocessor bus sequencer uses. Software can rewrite the whole control register at any time, including the type bit, to correct a wrong detection. The register port is a plain single-cycle control port. It has no valid/ready handshake, because a write never stalls and a read is always current.

Top module: `cop_type_latch`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cr0_rdata` is all zero, `type_wide` is 0 and `proto_wide` is 0.
- R2: If the synchronised error level is high (inactive) at the sample edge, the type bit (bit `TYPE_BIT`, default 4, of control register zero) is 0.
- R3: If the synchronised error level is low (active) at the sample edge, the type bit becomes 1.
- R4: `proto_wide` equals `type_wide` in every cycle, and `type_wide` always equals `cr0_rdata[TYPE_BIT]`. The value 1 selects the 32-bit protocol and 0 selects the 16-bit protocol.
- R5: With `esc_first` low, the sample is taken on the `SAMPLE_DLY`-th rising edge after `rst` falls (default 8). The type bit does not change before that edge.
- R6: If `esc_first` is high on an earlier rising edge while no sample has yet been taken, the sample is taken on that edge.
- R7: Only one sample is taken per reset. After it, changes on `err_n` or `esc_first` do not change the type bit.
- R8: When `cr0_we` is high, the whole register takes `cr0_wdata` on that edge. The write wins over a sample taken on the same edge.
- R9: `err_n` passes through two flops before it is sampled. A level on `err_n` that is present at edge `SAMPLE_DLY-2` is seen by the default sample. A level that first appears at edge `SAMPLE_DLY-1` is not seen.
- R10: A new reset clears the type bit and arms a fresh detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_n | input | 1 | Coprocessor error line, active low, asynchronous |
| esc_first | input | 1 | First escape instruction about to issue |
| cr0_we | input | 1 | Control register write strobe |
| cr0_wdata | input | REG_W | Control register write data |
| cr0_rdata | output | REG_W | Control register read data |
| type_wide | output | 1 | Type bit: 1 for the wide coprocessor type |
| proto_wide | output | 1 | Protocol select: 1 for 32-bit, 0 for 16-bit |

## Verification
Detection is run with the error line held high and held low. These two runs separate the narrow result from the wide one. A sample that lands on the timeout edge is told apart from one that lands a cycle early by checking the type bit one edge before the timeout edge and again on it. An early escape request shows whether the forced sample edge is honoured. Moving the error level one edge either side of the synchroniser limit confirms the two-flop depth. Toggling the line after detection, writing the register alone and writing it on the sample edge separate the one-shot latch from the override path. A second reset shows that detection is armed again.

// File: rtl/cop_type_pkg.sv
package cop_type_pkg;
  typedef enum logic {
    PROTO_16 = 1'b0,
    PROTO_32 = 1'b1
  } proto_e;

  function automatic proto_e level_to_proto(input logic err_level_n);
    return err_level_n ? PROTO_16 : PROTO_32;
  endfunction
endpackage

// File: rtl/cop_err_sync.sv
module cop_err_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b1;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/cop_sample_ctrl.sv
module cop_sample_ctrl #(
  parameter int SAMPLE_DLY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic esc_first,
  output logic sample_now
);
  localparam int CW = $clog2(SAMPLE_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign sample_now = !done_q && (esc_first || cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (sample_now) begin
      done_q <= 1'b1;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_once_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q && !sample_now);
  assert_take_R5: assert property (@(posedge clk) disable iff (rst)
    sample_now |=> done_q);
  assert_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/cop_ctrl_reg.sv
module cop_ctrl_reg
  import cop_type_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int TYPE_BIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_now,
  input  logic             err_sync_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] reg_q;
  proto_e           detected;

  assign detected = level_to_proto(err_sync_n);

  always_ff @(posedge clk) begin
    if (rst)             reg_q <= '0;
    else if (wr_en)      reg_q <= wr_data;
    else if (sample_now) reg_q[TYPE_BIT] <= logic'(detected);
  end

  assign rd_data = reg_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !sample_now |=> $stable(reg_q));
  assert_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> reg_q == $past(wr_data));
  assert_detect_R3: assert property (@(posedge clk) disable iff (rst)
    sample_now && !wr_en && !err_sync_n |=> reg_q[TYPE_BIT]);
endmodule

// File: rtl/cop_type_latch.sv
module cop_type_latch
  import cop_type_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int TYPE_BIT    = 4,
  parameter int SAMPLE_DLY  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_n,
  input  logic             esc_first,
  input  logic             cr0_we,
  input  logic [REG_W-1:0] cr0_wdata,
  output logic [REG_W-1:0] cr0_rdata,
  output logic             type_wide,
  output logic             proto_wide
);
  logic err_sync_n;
  logic sample_now;

  cop_err_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(err_n), .sync_out(err_sync_n)
  );

  cop_sample_ctrl #(.SAMPLE_DLY(SAMPLE_DLY)) u_ctrl (
    .clk(clk), .rst(rst), .esc_first(esc_first), .sample_now(sample_now)
  );

  cop_ctrl_reg #(.REG_W(REG_W), .TYPE_BIT(TYPE_BIT)) u_reg (
    .clk(clk), .rst(rst), .sample_now(sample_now), .err_sync_n(err_sync_n),
    .wr_en(cr0_we), .wr_data(cr0_wdata), .rd_data(cr0_rdata)
  );

  assign type_wide  = cr0_rdata[TYPE_BIT];
  assign proto_wide = (type_wide == logic'(PROTO_32));

  assert_sel_R4: assert property (@(posedge clk) disable iff (rst)
    proto_wide == type_wide);
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> cr0_rdata == '0);
endmodule

// File: tb/cop_type_latch_bench.sv
module cop_type_latch_bench;
  localparam int W = 32;
  localparam int TB = 4;
  localparam int DLY = 8;

  logic clk = 0, rst = 1, err_n = 1, esc_first = 0, cr0_we = 0;
  logic [W-1:0] cr0_wdata = '0, cr0_rdata;
  logic type_wide, proto_wide;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cop_type_latch #(.REG_W(W), .TYPE_BIT(TB), .SAMPLE_DLY(DLY)) u_cop_type_latch (
    .clk(clk), .rst(rst), .err_n(err_n), .esc_first(esc_first),
    .cr0_we(cr0_we), .cr0_wdata(cr0_wdata), .cr0_rdata(cr0_rdata),
    .type_wide(type_wide), .proto_wide(proto_wide)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // reset, then return at the negedge right after release (edge count 0)
  task automatic do_reset(input logic e);
    @(negedge clk);
    rst = 1; err_n = e; esc_first = 0; cr0_we = 0;
    edges(3);
    rst = 0;
  endtask

  task automatic t_reset_R1;
    @(negedge clk); rst = 1;
    edges(2);
    chk("R1 rdata", cr0_rdata, '0);
    chk("R1 type", type_wide, 0);
    chk("R1 proto", proto_wide, 0);
    rst = 0; edges(1);
    chk("R1 after release", cr0_rdata, '0);
  endtask

  task automatic t_narrow_R2;
    do_reset(1'b1);
    edges(DLY + 2);
    chk("R2 type", type_wide, 0);
    chk("R4 proto", proto_wide, 0);
  endtask

  task automatic t_wide_R3_R5;
    do_reset(1'b0);
    edges(DLY - 1);
    chk("R5 before edge", type_wide, 0);
    edges(1);
    chk("R3 type", type_wide, 1);
    chk("R4 proto", proto_wide, 1);
    chk("R4 rdata", cr0_rdata, W'(1) << TB);
  endtask

  task automatic t_early_R6;
    do_reset(1'b0);
    edges(3);
    chk("R6 not yet", type_wide, 0);
    esc_first = 1; edges(1); esc_first = 0;
    chk("R6 forced", type_wide, 1);
  endtask

  task automatic t_once_R7;
    do_reset(1'b0);
    edges(DLY);
    err_n = 1; edges(20);
    chk("R7 err change", type_wide, 1);
    esc_first = 1; edges(3); esc_first = 0;
    chk("R7 esc later", type_wide, 1);
  endtask

  task automatic t_write_R8;
    do_reset(1'b0);
    edges(DLY + 1);
    cr0_we = 1; cr0_wdata = 32'hA5A5_0003; edges(1); cr0_we = 0;
    chk("R8 write clear", cr0_rdata, 32'hA5A5_0003);
    chk("R8 proto", proto_wide, 0);
    cr0_we = 1; cr0_wdata = 32'h0000_0010; edges(1); cr0_we = 0;
    chk("R8 write set", type_wide, 1);
    // write on the sample edge wins
    do_reset(1'b0);
    edges(DLY - 1);
    cr0_we = 1; cr0_wdata = 32'h0000_0001; edges(1); cr0_we = 0;
    chk("R8 write wins", cr0_rdata, 32'h0000_0001);
    edges(2);
    chk("R8 no late sample", type_wide, 0);
  endtask

  task automatic t_sync_R9;
    do_reset(1'b1);
    edges(DLY - 3);   // now past edge DLY-3, before edge DLY-2
    err_n = 0;
    edges(3);
    chk("R9 seen", type_wide, 1);
    do_reset(1'b1);
    edges(DLY - 2);   // before edge DLY-1
    err_n = 0;
    edges(3);
    chk("R9 too late", type_wide, 0);
  endtask

  task automatic t_rearm_R10;
    do_reset(1'b0);
    edges(DLY);
    chk("R10 first", type_wide, 1);
    do_reset(1'b1);
    edges(1);
    chk("R10 cleared", type_wide, 0);
    err_n = 0; edges(DLY);
    chk("R10 redetect", type_wide, 1);
  endtask

  initial begin
    t_reset_R1();
    t_narrow_R2();
    t_wide_R3_R5();
    t_early_R6();
    t_once_R7();
    t_write_R8();
    t_sync_R9();
    t_rearm_R10();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule